// File: doc/BRIEF.md
# GPIO Bank Pin Lock Unit

This unit guards the configuration of a bank-organised GPIO peripheral against stray software writes. It keeps one lock word per bank, with one bit per pin. A set bit means the pin is locked. Other registers of the peripheral consult the unit through a combinational qualifier. That qualifier removes locked pins from a write mask, and it reports whether the control word of a single pin may be written.

A lock word is not changed by an ordinary store. Software must first store a fixed key to a global key register. The very next register write, whatever its address, uses up that arming. Only if that next write targets a lock register does the lock word take the written value. Any other write, or a key write with the wrong value, leaves the unit disarmed. Lock writes that arrive without arming are dropped without any indication. Reads do not affect the arming.

The register port is a plain, always-ready write/read port. There is no data stream, so no valid/ready handshake is used. A read returns its data one cycle after the request, marked by a valid strobe.

Top module: `pinlock_unit`

## Requirements
- R1: After reset every lock word is all-ones, so every pin starts locked, and the unit is disarmed.
- R2: A write of value 0x00A5A501 to byte address 0x520 arms the unit. If the next write goes to lock address 0x500 + 4*b (b below NUM_BANKS), lock word b takes the written data. The new value shows on `locked_o` in the cycle after that write.
- R3: A write to a lock address while the unit is disarmed is dropped, and the lock word keeps its value.
- R4: Any register write uses up the arming. A write to a non-lock address disarms the unit and changes no lock word. A wrong value written to 0x520 also disarms it. A correct key written while already armed keeps the unit armed. Reads neither arm nor disarm the unit.
- R5: `locked_o[32*b + i]` equals bit i of lock word b; 1 = locked, 0 = unlocked. All-zeros unlocks a whole bank and all-ones locks it.
- R6: `rd_valid` rises one cycle after `rd_en`, with `rdata` holding the addressed lock word. Reading 0x520 or any other address returns zero.
- R7: `q_allow_mask` = `q_wmask` with every bit of a locked pin in bank `q_bank` cleared, in the same cycle. An out-of-range bank gives zero.
- R8: `q_pin_allow` is 1 exactly when pin `q_pin` (global index 32*b + i) is unlocked, in the same cycle. An out-of-range pin gives 0.
- R9: A lock address whose bank index is NUM_BANKS or above changes no lock word, but it still uses up the arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | PIN_W | Write data |
| rdata | output | PIN_W | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data strobe, one cycle after `rd_en` |
| locked_o | output | NUM_BANKS*PIN_W | Per-pin lock state, bank-major |
| q_bank | input | 3 | Bank addressed by a mask write elsewhere |
| q_wmask | input | PIN_W | Pin mask of that write |
| q_allow_mask | output | PIN_W | Mask bits the write may touch |
| q_pin | input | 8 | Global pin whose control word is written |
| q_pin_allow | output | 1 | Control word write permitted |

## Verification
A lock write lands on `locked_o` one cycle after its write strobe. So the bench drives each write for one cycle starting at a falling edge, then reads `locked_o` at the following falling edge. Read data arrives one cycle after `rd_en`. A driver pushes each expected read word into a queue, and a monitor pops it on the falling edge where `rd_valid` is high. The qualifier outputs are combinational, so they are checked one nanosecond after their inputs change, with no clock edge in between.

// File: rtl/pinlock_pkg.sv
package pinlock_pkg;
  localparam int unsigned MAX_BANKS     = 8;
  localparam int unsigned BANK_SEL_W    = $clog2(MAX_BANKS);
  localparam logic [11:0] KEY_ADDR      = 12'h520;
  localparam logic [11:0] LOCK_BASE     = 12'h500;
  localparam logic [31:0] KEY_VALUE     = 32'h00A5A501;
endpackage

// File: rtl/pl_arm_ctrl.sv
module pl_arm_ctrl #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed_q
);
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(pinlock_pkg::KEY_ADDR);
  localparam logic [DATA_W-1:0] KEY_V = DATA_W'(pinlock_pkg::KEY_VALUE);

  logic key_hit;
  assign key_hit = (addr == KEY_A) && (wdata == KEY_V);

  // every write decides the next arming state; reads leave it alone
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_q <= 1'b0;
    else if (wr_en) armed_q <= key_hit;
  end
endmodule

// File: rtl/pl_lock_word.sv
module pl_lock_word #(
  parameter int unsigned PIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIN_W-1:0] wdata,
  output logic [PIN_W-1:0] word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '1;
    else if (load) word_q <= wdata;
  end
endmodule

// File: rtl/pl_write_qual.sv
module pl_write_qual #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned PIN_W     = 32,
  parameter int unsigned BSEL_W    = 3,
  parameter int unsigned PSEL_W    = 8
) (
  input  logic [NUM_BANKS*PIN_W-1:0] lock_flat,
  input  logic [BSEL_W-1:0]          q_bank,
  input  logic [PIN_W-1:0]           q_wmask,
  input  logic [PSEL_W-1:0]          q_pin,
  output logic [PIN_W-1:0]           q_allow_mask,
  output logic                       q_pin_allow
);
  localparam int unsigned TOTAL = NUM_BANKS * PIN_W;

  always_comb begin
    q_allow_mask = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (q_bank == BSEL_W'(b))
        q_allow_mask = q_wmask & ~lock_flat[b*PIN_W +: PIN_W];
    end
  end

  always_comb begin
    q_pin_allow = 1'b0;
    for (int p = 0; p < TOTAL; p++) begin
      if (q_pin == PSEL_W'(p)) q_pin_allow = ~lock_flat[p];
    end
  end
endmodule

// File: rtl/pinlock_unit.sv
module pinlock_unit #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned PIN_W     = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [PIN_W-1:0]           wdata,
  output logic [PIN_W-1:0]           rdata,
  output logic                       rd_valid,
  output logic [NUM_BANKS*PIN_W-1:0] locked_o,
  input  logic [2:0]                 q_bank,
  input  logic [PIN_W-1:0]           q_wmask,
  output logic [PIN_W-1:0]           q_allow_mask,
  input  logic [7:0]                 q_pin,
  output logic                       q_pin_allow
);
  localparam int unsigned BSEL_W = pinlock_pkg::BANK_SEL_W;
  localparam int unsigned BLK_SH = BSEL_W + 2;
  localparam logic [ADDR_W-1:0] LOCK_BLK = ADDR_W'(pinlock_pkg::LOCK_BASE >> BLK_SH);

  logic              armed_q;
  logic              is_lock;
  logic [BSEL_W-1:0] bank_idx;
  logic [PIN_W-1:0]  words [NUM_BANKS];
  logic [PIN_W-1:0]  rd_word;

  assign is_lock  = (addr[1:0] == 2'b00) && ((addr >> BLK_SH) == LOCK_BLK);
  assign bank_idx = addr[BLK_SH-1:2];

  pl_arm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(PIN_W)) u_arm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .armed_q(armed_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic load_b;
    assign load_b = wr_en && armed_q && is_lock && (bank_idx == BSEL_W'(b));
    pl_lock_word #(.PIN_W(PIN_W)) u_word (
      .clk(clk), .rst_n(rst_n), .load(load_b), .wdata(wdata), .word_q(words[b])
    );
    assign locked_o[b*PIN_W +: PIN_W] = words[b];
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (is_lock && bank_idx == BSEL_W'(b)) rd_word = words[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  pl_write_qual #(.NUM_BANKS(NUM_BANKS), .PIN_W(PIN_W), .BSEL_W(3), .PSEL_W(8)) u_qual (
    .lock_flat(locked_o), .q_bank(q_bank), .q_wmask(q_wmask), .q_pin(q_pin),
    .q_allow_mask(q_allow_mask), .q_pin_allow(q_pin_allow)
  );
endmodule

// File: rtl/pinlock_unit_chk.sv
module pinlock_unit_chk #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned PIN_W     = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic [ADDR_W-1:0]          addr,
  input logic [PIN_W-1:0]           wdata,
  input logic [PIN_W-1:0]           rdata,
  input logic                       rd_valid,
  input logic [NUM_BANKS*PIN_W-1:0] locked_o,
  input logic [PIN_W-1:0]           q_wmask,
  input logic [PIN_W-1:0]           q_allow_mask,
  input logic                       armed_q
);
  localparam logic [ADDR_W-1:0] KA = ADDR_W'(pinlock_pkg::KEY_ADDR);
  localparam logic [PIN_W-1:0]  KV = PIN_W'(pinlock_pkg::KEY_VALUE);

  a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == KA && wdata == KV) |=> armed_q);

  a_r4_write_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(addr == KA && wdata == KV)) |=> !armed_q);

  a_r4_reads_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(armed_q));

  a_r3_no_unarmed_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(locked_o) |-> $past(armed_q && wr_en));

  a_r6_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r6_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == KA) |=> (rdata == '0));

  a_r7_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (q_allow_mask & ~q_wmask) == '0);
endmodule

bind pinlock_unit pinlock_unit_chk #(.NUM_BANKS(NUM_BANKS), .PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .rd_valid(rd_valid), .locked_o(locked_o), .q_wmask(q_wmask),
  .q_allow_mask(q_allow_mask), .armed_q(armed_q)
);

// File: tb/sim_pinlock_unit.sv
module sim_pinlock_unit;
  localparam int NB = 4;
  localparam int PW = 32;
  localparam int AW = 12;
  localparam logic [AW-1:0] KEY_A = 12'h520;
  localparam logic [PW-1:0] KEY_V = 32'h00A5A501;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [PW-1:0] wdata = '0, rdata, q_wmask = '0, q_allow_mask;
  logic rd_valid, q_pin_allow;
  logic [NB*PW-1:0] locked_o;
  logic [2:0] q_bank = '0;
  logic [7:0] q_pin = '0;

  int n_tests = 0, n_fail = 0;
  logic [PW-1:0] m_lock [NB];
  logic m_armed = 0;
  logic [PW-1:0] exp_q [$];
  string tag_q [$];

  always #4 clk = ~clk;

  pinlock_unit #(.NUM_BANKS(NB), .PIN_W(PW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .locked_o(locked_o), .q_bank(q_bank),
    .q_wmask(q_wmask), .q_allow_mask(q_allow_mask), .q_pin(q_pin), .q_pin_allow(q_pin_allow)
  );

  task automatic check(string req, logic [NB*PW-1:0] act, logic [NB*PW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NB*PW-1:0] model_flat();
    logic [NB*PW-1:0] f;
    for (int b = 0; b < NB; b++) f[b*PW +: PW] = m_lock[b];
    return f;
  endfunction

  task automatic wr(logic [AW-1:0] a, logic [PW-1:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    if (m_armed && a[1:0] == 0 && a[11:5] == 7'h28 && a[4:2] < NB) m_lock[a[4:2]] = d;
    m_armed = (a == KEY_A) && (d == KEY_V);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [PW-1:0] exp, string req);
    @(negedge clk);
    rd_en = 1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 0;
  endtask

  // monitor: pops expected read words as rd_valid presents them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R6 unexpected read", 1, 0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  logic done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) m_lock[b] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset locks", locked_o, '1);
    rd(12'h500, 32'hFFFFFFFF, "R6 read bank0");
    rd(KEY_A, 32'h0, "R6 key reads zero");
    // R3: unarmed lock write dropped
    wr(12'h500, 32'h0);
    check("R3 unarmed dropped", locked_o, model_flat());
    // R2/R5: armed write to bank1
    wr(KEY_A, KEY_V); wr(12'h504, 32'h0000FF00);
    check("R2 armed write", locked_o, model_flat());
    check("R5 bit 40 locked", locked_o[40], 1);
    check("R5 bit 32 unlocked", locked_o[32], 0);
    rd(12'h504, 32'h0000FF00, "R6 read bank1");
    // R4: other address consumes arming
    wr(KEY_A, KEY_V); wr(12'h100, 32'h0); wr(12'h504, 32'h0);
    check("R4 other write disarms", locked_o, model_flat());
    // R4: read does not disarm
    wr(KEY_A, KEY_V); rd(12'h50C, 32'hFFFFFFFF, "R6 read bank3"); wr(12'h508, 32'h0);
    check("R4 read keeps arming", locked_o[95:64], 32'h0);
    // R4: wrong key disarms
    wr(KEY_A, 32'h00A5A500); wr(12'h508, 32'hFFFFFFFF);
    check("R4 wrong key dropped", locked_o[95:64], 32'h0);
    // R4: repeated key keeps armed
    wr(KEY_A, KEY_V); wr(KEY_A, KEY_V); wr(12'h50C, 32'h0);
    check("R4 rearm applies", locked_o[127:96], 32'h0);
    // R5: all-ones relocks bank
    wr(KEY_A, KEY_V); wr(12'h50C, 32'hFFFFFFFF);
    check("R5 all-ones locks", locked_o[127:96], 32'hFFFFFFFF);
    // R9: bank beyond range consumes arming, changes nothing
    wr(KEY_A, KEY_V); wr(12'h514, 32'h0); wr(12'h500, 32'h0);
    check("R9 out-of-range bank", locked_o, model_flat());
    // R7/R8 qualifier
    @(negedge clk);
    q_bank = 3'd1; q_wmask = 32'hFFFFFFFF; #1;
    check("R7 bank1 mask", q_allow_mask, 32'hFFFF00FF);
    q_bank = 3'd0; #1;
    check("R7 bank0 mask", q_allow_mask, 32'h0);
    q_bank = 3'd6; #1;
    check("R7 out-of-range bank", q_allow_mask, 32'h0);
    q_pin = 8'd40; #1;
    check("R8 locked pin", q_pin_allow, 0);
    q_pin = 8'd33; #1;
    check("R8 unlocked pin", q_pin_allow, 1);
    q_pin = 8'd70; #1;
    check("R8 bank2 pin", q_pin_allow, 1);
    q_pin = 8'd200; #1;
    check("R8 out-of-range pin", q_pin_allow, 0);
    repeat (3) @(negedge clk);
    check("R6 reads drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule